// File: doc/BRIEF.md
# Half-Duplex Buffered SPI Master

A register-mapped SPI master that runs one buffered, half-duplex transaction at a time. Software fills a 32-bit command word and eight 32-bit data words. It then programs three bit counts: command bits, outgoing data bits and incoming data bits. Writing the start bit launches the engine. The engine first shifts the command bits out of the command word, then the outgoing data bits out of the data words, and finally captures the incoming bits into those same data words. A busy flag stays up for the whole transaction.

The block contains the register file, a programmable SCK divider (period of N+2 system clocks), an LSB-first option and one software-driven select bit per device. Only SPI mode 0 exists: SCK idles low, MISO is captured on the rising SCK edge, and MOSI changes only on the falling edge. Select lines are fully under software control, so one select can stay asserted across several transactions.

Top module: `hd_spi_master`

## Requirements
- R1: After reset, busy and all registers read 0, SCK is 0 and every cs_n line is 1.
- R2: Writing 1 to bit 8 of offset 0x00 starts a transaction when the engine is idle. Bit 16 of 0x00 reads 1 until the transaction ends, and bit 8 always reads 0.
- R3: The phase counts register at 0x2C holds the command bit count in bits 31:24, the receive bit count in bits 20:12 and the transmit data bit count in bits 8:0. The command, transmit and receive phases run in that order, and the number of SCK rising edges equals the sum of the three counts.
- R4: The command word at 0x04 is sent most significant byte first (bits 31:24 first).
- R5: Transmit data bytes come from the data words at 0x08..0x24, low byte first, starting with bits 7:0 of the word at 0x08.
- R6: Receive bits are sampled on the SCK rising edge and packed into the data words, with the first byte in bits 7:0 of 0x08. Bytes that are not received keep their contents.
- R7: Bit 3 of the configuration register at 0x28 selects LSB-first bit order within each byte, for both directions. When it is 0, bytes are MSB first.
- R8: Bits 27:16 of 0x28 hold N. Each SCK period lasts N+2 system clocks, with SCK low for floor((N+2)/2) clocks and high for the remainder.
- R9: Configuration bits 5:4 always read 0 and have no effect: operation stays in mode 0.
- R10: Bit k of 0x38 drives cs_n[k] low when set. Chip selects do not change while busy.
- R11: While busy, register writes are ignored, including a second start.
- R12: A start with all three counts at 0 clears busy by the second clock edge and produces no SCK edge.
- R13: SCK idles low, and MOSI keeps its last driven bit through the receive phase and after the end.
- R14: A command count above 32 is treated as 32, and a data count above 256 is treated as 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Byte address of the register; writes need bits 1:0 = 0 |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| sck | output | 1 | SPI clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | NCS | Active-low device selects |

## Verification
On every cycle, the embedded properties check four things: SCK is low whenever the engine is idle; MOSI moves only at a start or a falling SCK edge; selects and the command word stay frozen while busy; and an empty transaction ends at once. The directed scenarios are the only place where the content and order of the bit stream can be seen. That covers command-byte ordering against data-byte ordering, the LSB-first option, packing of received bytes, the high time produced by a divider value, count clamping, and the readback that proves writes during busy were discarded.

// File: rtl/hd_spi_master.sv
module hd_spi_master #(
  parameter int NCS = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_we,
  input  logic [5:0]     reg_addr,
  input  logic [31:0]    reg_wdata,
  output logic [31:0]    reg_rdata,
  output logic           sck,
  output logic           mosi,
  input  logic           miso,
  output logic [NCS-1:0] cs_n
);

  logic [31:0]    op;
  logic [255:0]   dbuf;
  logic [11:0]    div;
  logic           lsb;
  logic [7:0]     cmdf;
  logic [8:0]     txf, rxf;
  logic [NCS-1:0] csr;
  logic           busy;
  logic [12:0]    cnt;
  logic [9:0]     pos;

  logic [5:0]  cmd_n;
  logic [8:0]  tx_n, rx_n;
  logic [9:0]  txe, total, sel_pos, dj, rj;
  logic [12:0] period, lowc;
  logic [3:0]  widx, dwi;
  logic [7:0]  ridx;
  logic        tx_sel, wr_ok;
  logic        unused_bits;

  assign cmd_n  = (cmdf > 8'd32) ? 6'd32 : cmdf[5:0];
  assign tx_n   = (txf > 9'd256) ? 9'd256 : txf;
  assign rx_n   = (rxf > 9'd256) ? 9'd256 : rxf;
  assign txe    = {4'b0, cmd_n} + {1'b0, tx_n};
  assign total  = txe + {1'b0, rx_n};
  assign period = {1'b0, div} + 13'd2;
  assign lowc   = period >> 1;

  assign sel_pos = busy ? pos + 10'd1 : 10'd0;
  assign dj      = sel_pos - {4'b0, cmd_n};
  assign tx_sel  = (sel_pos < {4'b0, cmd_n})
                 ? op[{~sel_pos[4:3], lsb ? sel_pos[2:0] : ~sel_pos[2:0]}]
                 : dbuf[lsb ? dj[7:0] : {dj[7:3], ~dj[2:0]}];
  assign rj      = pos - txe;
  assign ridx    = lsb ? rj[7:0] : {rj[7:3], ~rj[2:0]};

  assign widx  = reg_addr[5:2];
  assign dwi   = widx - 4'd2;
  assign wr_ok = reg_we && !busy && (reg_addr[1:0] == 2'b00);
  assign cs_n  = ~csr;
  assign unused_bits = ^{reg_wdata, reg_addr[1:0], dj[9:8], rj[9:8]};

  always_comb begin
    reg_rdata = 32'h0;
    case (widx)
      4'd0:  reg_rdata = {15'b0, busy, 16'b0};
      4'd1:  reg_rdata = op;
      4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7, 4'd8, 4'd9:
             reg_rdata = dbuf[{dwi[2:0], 5'b0} +: 32];
      4'd10: reg_rdata = {4'b0, div, 12'b0, lsb, 3'b0};
      4'd11: reg_rdata = {cmdf, 3'b0, rxf, 3'b0, txf};
      4'd14: reg_rdata = {{(32-NCS){1'b0}}, csr};
      default: reg_rdata = 32'h0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op   <= '0;
      dbuf <= '0;
      div  <= '0;
      lsb  <= 1'b0;
      cmdf <= '0;
      txf  <= '0;
      rxf  <= '0;
      csr  <= '0;
      busy <= 1'b0;
      cnt  <= '0;
      pos  <= '0;
      sck  <= 1'b0;
      mosi <= 1'b0;
    end else if (busy) begin
      if (total == 10'd0) begin
        busy <= 1'b0;
      end else if (cnt == lowc - 13'd1) begin
        sck <= 1'b1;
        cnt <= cnt + 13'd1;
        if (pos >= txe) dbuf[ridx] <= miso;
      end else if (cnt == period - 13'd1) begin
        sck <= 1'b0;
        cnt <= '0;
        if (pos == total - 10'd1) begin
          busy <= 1'b0;
        end else begin
          pos <= pos + 10'd1;
          if (pos + 10'd1 < txe) mosi <= tx_sel;
        end
      end else begin
        cnt <= cnt + 13'd1;
      end
    end else if (wr_ok) begin
      case (widx)
        4'd0: if (reg_wdata[8]) begin
          busy <= 1'b1;
          pos  <= '0;
          cnt  <= '0;
          if (txe != 10'd0) mosi <= tx_sel;
        end
        4'd1: op <= reg_wdata;
        4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7, 4'd8, 4'd9:
          dbuf[{dwi[2:0], 5'b0} +: 32] <= reg_wdata;
        4'd10: begin
          div <= reg_wdata[27:16];
          lsb <= reg_wdata[3];
        end
        4'd11: begin
          cmdf <= reg_wdata[31:24];
          rxf  <= reg_wdata[20:12];
          txf  <= reg_wdata[8:0];
        end
        4'd14: csr <= reg_wdata[NCS-1:0];
        default: ;
      endcase
    end
  end

  // R13
  sck_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sck);

  // R13
  mosi_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mosi) |-> ($fell(sck) || $rose(busy)));

  // R10
  cs_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(cs_n));

  // R11
  op_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(op));

  // R12
  empty_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && total == 10'd0) |=> !busy);

endmodule

// File: tb/tb_hd_spi_master.sv
module tb_hd_spi_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        sck, mosi;
  logic        miso = 1'b0;
  logic [1:0]  cs_n;

  int tests = 0;
  int fails = 0;
  int rises = 0;
  int hicnt = 0;
  int nexp  = 0;
  logic sampled [0:599];
  logic resp    [0:599];
  logic expv    [0:599];

  always #10 clk = ~clk;

  hd_spi_master #(.NCS(2)) dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sck(sck), .mosi(mosi),
    .miso(miso), .cs_n(cs_n)
  );

  always @(posedge sck) begin
    if (rises < 600) sampled[rises] = mosi;
    rises++;
  end
  always @(negedge sck) if (rises < 600) miso = resp[rises];
  always @(negedge clk) if (sck) hicnt++;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic push_byte(input logic [7:0] b, input bit lsbf);
    for (int k = 0; k < 8; k++) begin
      expv[nexp] = lsbf ? b[k] : b[7-k];
      nexp++;
    end
  endtask

  task automatic prep();
    nexp = 0; rises = 0;
    for (int i = 0; i < 600; i++) resp[i] = 1'b0;
  endtask

  task automatic set_resp(input int at, input logic [7:0] b, input bit lsbf);
    for (int k = 0; k < 8; k++) resp[at+k] = lsbf ? b[k] : b[7-k];
  endtask

  task automatic run();
    logic [31:0] v;
    miso = resp[0];
    rises = 0;
    wr(6'h00, 32'h100);
    for (int i = 0; i < 20000; i++) begin
      rd(6'h00, v);
      if (v[16] == 1'b0) break;
    end
  endtask

  task automatic cmp_stream(input string tag);
    int bad = 0;
    chk({tag, " edges"}, rises, nexp);
    for (int i = 0; i < nexp; i++) if (sampled[i] !== expv[i]) bad++;
    chk({tag, " stream mismatches"}, bad, 0);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(6'h00, v); chk("R1 ctrl", v, 0);
    rd(6'h04, v); chk("R1 op", v, 0);
    rd(6'h08, v); chk("R1 data0", v, 0);
    rd(6'h28, v); chk("R1 cfg", v, 0);
    rd(6'h2C, v); chk("R1 counts", v, 0);
    rd(6'h38, v); chk("R1 cs", v, 0);
    chk("R1 sck", {31'b0, sck}, 0);
    chk("R1 cs_n", {30'b0, cs_n}, 32'h3);
  endtask

  task automatic t_cs();
    wr(6'h38, 32'h1); @(negedge clk); chk("R10 cs0", {30'b0, cs_n}, 32'h2);
    wr(6'h38, 32'h2); @(negedge clk); chk("R10 cs1", {30'b0, cs_n}, 32'h1);
  endtask

  task automatic t_write_msb();
    logic [31:0] v;
    prep();
    wr(6'h28, 32'h0);
    wr(6'h04, 32'hA1B2C3D4);
    wr(6'h08, 32'h00002311);
    wr(6'h2C, (32'd16 << 24) | 32'd16);
    rd(6'h2C, v); chk("R3 counts readback", v, 32'h10000010);
    push_byte(8'hA1, 0); push_byte(8'hB2, 0); push_byte(8'h11, 0); push_byte(8'h23, 0);
    hicnt = 0;
    run();
    cmp_stream("R3 R4 R5 cmd then data");
    chk("R8 high clocks div0", hicnt, 32);
  endtask

  task automatic t_start_flag();
    logic [31:0] v;
    wr(6'h28, 32'h0);
    wr(6'h04, 32'h0);
    wr(6'h2C, 32'd8 << 24);
    wr(6'h00, 32'h100);
    rd(6'h00, v);
    chk("R2 busy set, start reads 0", v & 32'h00010100, 32'h00010000);
    for (int i = 0; i < 100; i++) begin
      rd(6'h00, v);
      if (v[16] == 1'b0) break;
    end
    chk("R2 busy clears", v, 0);
  endtask

  task automatic t_read();
    logic [31:0] v;
    prep();
    wr(6'h04, 32'h9F000000);
    wr(6'h2C, (32'd8 << 24) | (32'd24 << 12));
    push_byte(8'h9F, 0);
    set_resp(8, 8'h5A, 0); set_resp(16, 8'hC3, 0); set_resp(24, 8'h0F, 0);
    for (int i = 0; i < 24; i++) expv[8+i] = 1'bx;
    run();
    chk("R3 edges cmd+rx", rises, 32);
    begin
      int bad = 0;
      for (int i = 0; i < 8; i++) if (sampled[i] !== expv[i]) bad++;
      chk("R3 command first", bad, 0);
    end
    rd(6'h08, v); chk("R6 rx packing", v, 32'h000FC35A);
    chk("R13 mosi held", {31'b0, mosi}, 1);
    chk("R13 sck idle", {31'b0, sck}, 0);
  endtask

  task automatic t_lsb();
    logic [31:0] v;
    prep();
    wr(6'h28, 32'h8);
    wr(6'h04, 32'h35000000);
    wr(6'h08, 32'h0000006C);
    wr(6'h2C, (32'd8 << 24) | (32'd8 << 12) | 32'd8);
    push_byte(8'h35, 1); push_byte(8'h6C, 1);
    set_resp(16, 8'hA5, 1);
    run();
    chk("R7 edges", rises, 24);
    begin
      int bad = 0;
      for (int i = 0; i < 16; i++) if (sampled[i] !== expv[i]) bad++;
      chk("R7 lsb-first tx", bad, 0);
    end
    rd(6'h08, v); chk("R7 lsb-first rx", v, 32'h000000A5);
  endtask

  task automatic t_mode();
    logic [31:0] v;
    prep();
    wr(6'h28, 32'h30);
    rd(6'h28, v); chk("R9 mode bits read 0", v, 0);
    wr(6'h04, 32'hC3000000);
    wr(6'h2C, 32'd8 << 24);
    chk("R9 sck idle before", {31'b0, sck}, 0);
    push_byte(8'hC3, 0);
    run();
    cmp_stream("R9 mode0 stream");
  endtask

  task automatic t_div();
    logic [31:0] v;
    prep();
    wr(6'h28, 32'd3 << 16);
    rd(6'h28, v); chk("R8 div readback", v, 32'h00030000);
    wr(6'h04, 32'hC3000000);
    wr(6'h2C, 32'd8 << 24);
    push_byte(8'hC3, 0);
    hicnt = 0;
    run();
    cmp_stream("R8 div3 stream");
    chk("R8 high clocks div3", hicnt, 24);
  endtask

  task automatic t_busy_ign();
    logic [31:0] v;
    prep();
    wr(6'h38, 32'h1);
    wr(6'h28, 32'd3 << 16);
    wr(6'h04, 32'hDEADBEEF);
    wr(6'h2C, 32'd32 << 24);
    push_byte(8'hDE, 0); push_byte(8'hAD, 0); push_byte(8'hBE, 0); push_byte(8'hEF, 0);
    miso = 1'b0; rises = 0;
    wr(6'h00, 32'h100);
    rd(6'h00, v); chk("R11 busy during", v[16], 1);
    wr(6'h04, 32'h12345678);
    wr(6'h38, 32'h2);
    wr(6'h00, 32'h100);
    for (int i = 0; i < 2000; i++) begin
      rd(6'h00, v);
      if (v[16] == 1'b0) break;
    end
    rd(6'h04, v); chk("R11 op unchanged", v, 32'hDEADBEEF);
    chk("R11 cs unchanged", {30'b0, cs_n}, 32'h2);
    repeat (20) @(negedge clk);
    cmp_stream("R11 no restart");
  endtask

  task automatic t_zero();
    logic [31:0] v;
    wr(6'h2C, 32'h0);
    rises = 0;
    wr(6'h00, 32'h100);
    rd(6'h00, v);
    chk("R12 done in two cycles", v, 0);
    chk("R12 no sck", rises, 0);
  endtask

  task automatic t_clamp();
    prep();
    wr(6'h28, 32'h0);
    wr(6'h04, 32'h0F0F0F0F);
    wr(6'h2C, 32'd40 << 24);
    for (int i = 0; i < 4; i++) push_byte(8'h0F, 0);
    run();
    cmp_stream("R14 cmd clamp");
  endtask

  initial begin
    #4000000;
    fails++; tests++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_cs();
    t_write_msb();
    t_start_flag();
    t_read();
    t_lsb();
    t_mode();
    t_div();
    t_busy_ign();
    t_zero();
    t_clamp();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule